// File: doc/BRIEF.md
# Dual-Clock Serial Memory Streamer

This block streams the contents of a small byte-wide memory as a continuous serial bit stream, paced by a slow display-side clock that is sampled into the system clock domain. After reset the block holds the data line released while it counts a fixed number of warm-up edges on that stream clock. It then presents one bit per rising edge. Each byte goes out most significant bit first and is followed by an empty slot in which the line is released. When the last address has been sent the pointer wraps to zero and streaming goes on without a gap.

A second sampled input, the bus clock of a two-wire slave, is expected to stay high while streaming. A qualified falling edge on it hands the data line over for good. The block raises a one-cycle switch pulse and a level flag, releases the line, and stops advancing. From then on the stream clock input only serves as a write-enable level for the slave logic. Only reset restores streaming. The memory sits outside the block and is read through an address output and a data input with one cycle of read latency.

Top module: `serial_rom_streamer`

## Requirements
- R1: After reset `sda_oe` is 0, `rd_addr` is 0, `two_wire` is 0, `mode_switch` is 0 and `wr_enable` is 0.
- R2: During the first INIT_EDGES (default nine) accepted rising edges of `vclk_in` after reset, `sda_oe` stays 0.
- R3: The next accepted rising edge sets `sda_oe` to 1 and `sda_out` to bit 7 (the MSB) of the byte at address 0.
- R4: Each following accepted rising edge drives the next lower bit of the current byte on `sda_out` with `sda_oe` at 1. Falling edges of `vclk_in` change nothing.
- R5: The edge after bit 0 of a byte is a null slot: `sda_oe` becomes 0 and `rd_addr` advances by exactly one. The next edge starts the following byte at its MSB.
- R6: After the null slot of the last address (2^ADDR_W - 1), `rd_addr` wraps to 0 and the next bits come from the byte at address 0.
- R7: A level on `vclk_in` or `scl_in` that lasts, after the synchroniser, fewer than STABLE_CYC system clocks is ignored: it advances no bit and causes no mode change.
- R8: An accepted falling edge of `scl_in` in streaming mode sets `two_wire` to 1 and raises `mode_switch` for exactly one clock cycle.
- R9: Once set, `two_wire` stays 1 until reset. Later edges on `scl_in` produce no further `mode_switch` pulse.
- R10: While `two_wire` is 1, `sda_oe` is 0 and edges on `vclk_in` do not change `rd_addr`.
- R11: `wr_enable` follows the filtered level of `vclk_in` while `two_wire` is 1, and is 0 in streaming mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (models power-on) |
| vclk_in | input | 1 | Asynchronous stream clock; write-enable level in two-wire mode |
| scl_in | input | 1 | Asynchronous two-wire bus clock, watched for the mode switch |
| rd_addr | output | ADDR_W | Memory read address (stream pointer) |
| rd_data | input | DATA_W | Memory read data, valid one cycle after `rd_addr` |
| sda_oe | output | 1 | Data line drive enable (0 = released) |
| sda_out | output | 1 | Data line value while `sda_oe` is 1 |
| two_wire | output | 1 | Level flag: line belongs to the two-wire slave |
| mode_switch | output | 1 | One-cycle pulse when the line is handed over |
| wr_enable | output | 1 | Write-enable level for the slave in two-wire mode |

## Verification
The bench builds the block with ADDR_W set to 4 and STABLE_CYC set to 3, leaving the other parameters at their defaults. The shorter array brings the pointer wrap within a few hundred stream edges, so the run covers full byte framing, several null slots and a complete trip back to address 0. The longer stability window makes two-cycle glitches on both sampled clocks a clean rejection case, distinct from the eight-cycle phases the bench uses for real edges.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic {
    PH_WARMUP = 1'b0,
    PH_STREAM = 1'b1
  } stream_phase_t;
endpackage

// File: rtl/srs_in_filter.sv
module srs_in_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   STABLE_CYC  = 2,
  parameter logic RST_LEVEL   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic changed
);
  localparam int RUN_W = $clog2(STABLE_CYC + 1);

  logic [SYNC_STAGES-1:0] chain;
  logic                   sy;
  logic                   last;
  logic [RUN_W-1:0]       run;
  logic [RUN_W-1:0]       run_n;
  logic                   accept;

  always_ff @(posedge clk) begin
    if (rst) chain <= {SYNC_STAGES{RST_LEVEL}};
    else     chain <= {chain[SYNC_STAGES-2:0], din};
  end

  assign sy = chain[SYNC_STAGES-1];

  always_comb begin
    if (sy != last)                        run_n = RUN_W'(1);
    else if (run == RUN_W'(STABLE_CYC))    run_n = run;
    else                                   run_n = run + 1'b1;
    accept = (run_n == RUN_W'(STABLE_CYC)) && (sy != level);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last    <= RST_LEVEL;
      run     <= RUN_W'(STABLE_CYC);
      level   <= RST_LEVEL;
      changed <= 1'b0;
    end else begin
      last    <= sy;
      run     <= run_n;
      changed <= accept;
      if (accept) level <= sy;
    end
  end
endmodule

// File: rtl/srs_bit_seq.sv
module srs_bit_seq #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int INIT_EDGES = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              halt,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              oe,
  output logic              val
);
  import srs_pkg::*;

  localparam int IW = $clog2(INIT_EDGES + 1);
  localparam int SW = $clog2(DATA_W + 1);

  stream_phase_t     phase;
  logic [IW-1:0]     init_cnt;
  logic [SW-1:0]     slot;
  logic [DATA_W-1:0] shifted;

  assign shifted = rd_data << slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_WARMUP;
      init_cnt <= '0;
      slot     <= '0;
      addr     <= '0;
      oe       <= 1'b0;
      val      <= 1'b1;
    end else if (halt) begin
      oe  <= 1'b0;
      val <= 1'b1;
    end else if (step) begin
      if (phase == PH_WARMUP) begin
        init_cnt <= init_cnt + 1'b1;
        if (init_cnt == IW'(INIT_EDGES - 1)) phase <= PH_STREAM;
      end else if (slot == SW'(DATA_W)) begin
        oe   <= 1'b0;
        val  <= 1'b1;
        slot <= '0;
        addr <= addr + 1'b1;
      end else begin
        oe   <= 1'b1;
        val  <= shifted[DATA_W-1];
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srs_mode_latch.sv
module srs_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic bus_fall,
  input  logic vclk_level,
  output logic two_wire,
  output logic mode_switch,
  output logic halt
);
  logic we_q;

  assign halt = two_wire | bus_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      two_wire    <= 1'b0;
      mode_switch <= 1'b0;
      we_q        <= 1'b0;
    end else begin
      mode_switch <= bus_fall & ~two_wire;
      if (bus_fall) two_wire <= 1'b1;
      we_q <= halt & vclk_level;
    end
  end
endmodule

// File: rtl/serial_rom_streamer.sv
module serial_rom_streamer #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2,
  parameter int INIT_EDGES  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vclk_in,
  input  logic              scl_in,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              sda_out,
  output logic              two_wire,
  output logic              mode_switch,
  output logic              wr_enable
);
  logic v_lvl, v_chg, s_lvl, s_chg;
  logic vclk_rise, bus_fall, halt;

  srs_in_filter #(
    .SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC), .RST_LEVEL(1'b0)
  ) u_vclk_flt (
    .clk(clk), .rst(rst), .din(vclk_in), .level(v_lvl), .changed(v_chg)
  );

  srs_in_filter #(
    .SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC), .RST_LEVEL(1'b1)
  ) u_scl_flt (
    .clk(clk), .rst(rst), .din(scl_in), .level(s_lvl), .changed(s_chg)
  );

  assign vclk_rise = v_chg & v_lvl;
  assign bus_fall  = s_chg & ~s_lvl;

  srs_mode_latch u_mode (
    .clk(clk), .rst(rst), .bus_fall(bus_fall), .vclk_level(v_lvl),
    .two_wire(two_wire), .mode_switch(mode_switch), .halt(halt)
  );

  assign wr_enable = u_mode.we_q;

  srs_bit_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_EDGES(INIT_EDGES)
  ) u_seq (
    .clk(clk), .rst(rst), .step(vclk_rise), .halt(halt), .rd_data(rd_data),
    .addr(rd_addr), .oe(sda_oe), .val(sda_out)
  );
endmodule

// File: rtl/srs_checks.sv
module srs_checks #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              sda_oe,
  input logic              two_wire,
  input logic              mode_switch,
  input logic              wr_enable
);
  AST_SWITCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mode_switch |=> !mode_switch); // R8
  AST_SWITCH_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    mode_switch |-> two_wire); // R8
  AST_FLAG_RISE_PULSED: assert property (@(posedge clk) disable iff (rst)
    $rose(two_wire) |-> mode_switch); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    two_wire |=> two_wire); // R9
  AST_LINE_RELEASED_2W: assert property (@(posedge clk) disable iff (rst)
    two_wire |-> !sda_oe); // R10
  AST_ADDR_FROZEN_2W: assert property (@(posedge clk) disable iff (rst)
    $past(two_wire) |-> $stable(rd_addr)); // R10
  AST_ADDR_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_addr) |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1)); // R6
  AST_WREN_ONLY_2W: assert property (@(posedge clk) disable iff (rst)
    wr_enable |-> two_wire); // R11
endmodule

bind serial_rom_streamer srs_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rd_addr(rd_addr), .sda_oe(sda_oe),
  .two_wire(two_wire), .mode_switch(mode_switch), .wr_enable(wr_enable)
);

// File: tb/serial_rom_streamer_bench.sv
module serial_rom_streamer_bench;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int HOLD  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vclk_in = 1'b0;
  logic          scl_in = 1'b1;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          sda_oe, sda_out, two_wire, mode_switch, wr_enable;

  int total = 0;
  int bad = 0;
  int ms_cnt = 0;
  int exp_addr = 0;

  always #5 clk = ~clk;

  serial_rom_streamer #(.ADDR_W(AW), .DATA_W(DW), .STABLE_CYC(3)) u_serial_rom_streamer (
    .clk(clk), .rst(rst), .vclk_in(vclk_in), .scl_in(scl_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .sda_oe(sda_oe), .sda_out(sda_out),
    .two_wire(two_wire), .mode_switch(mode_switch), .wr_enable(wr_enable)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 29 + 8'hA5);
  endfunction

  always_ff @(posedge clk) rd_data <= pat(int'(rd_addr));

  always @(negedge clk) if (!rst && mode_switch) ms_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vclk_high();
    vclk_in = 1'b1;
    cycles(HOLD);
  endtask

  task automatic vclk_low();
    vclk_in = 1'b0;
    cycles(HOLD);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; vclk_in = 1'b0; scl_in = 1'b1;
    cycles(3);
    rst = 1'b0;
    cycles(HOLD);
    exp_addr = 0;
  endtask

  task automatic t_reset_state();
    chk("R1 oe", {31'd0, sda_oe}, 0);
    chk("R1 addr", {28'd0, rd_addr}, 0);
    chk("R1 two_wire", {31'd0, two_wire}, 0);
    chk("R1 mode_switch", {31'd0, mode_switch}, 0);
    chk("R1 wr_enable", {31'd0, wr_enable}, 0);
  endtask

  task automatic t_warmup();
    for (int i = 0; i < 9; i++) begin
      vclk_high();
      chk("R2 released during warm-up", {31'd0, sda_oe}, 0);
      vclk_low();
    end
    vclk_high();
    chk("R3 drive on tenth edge", {31'd0, sda_oe}, 1);
    chk("R3 MSB of address 0", {31'd0, sda_out}, {31'd0, pat(0)[DW-1]});
    vclk_low();
    chk("R4 falling edge keeps bit", {31'd0, sda_out}, {31'd0, pat(0)[DW-1]});
  endtask

  task automatic t_stream(input int nbytes, input int first_bit);
    int fb;
    fb = first_bit;
    for (int n = 0; n < nbytes; n++) begin
      for (int b = fb; b >= 0; b--) begin
        vclk_high();
        chk("R4 drive", {31'd0, sda_oe}, 1);
        chk("R4 bit", {31'd0, sda_out}, {31'd0, pat(exp_addr)[b]});
        chk("R11 no write enable while streaming", {31'd0, wr_enable}, 0);
        vclk_low();
      end
      vclk_high();
      chk("R5 null slot released", {31'd0, sda_oe}, 0);
      exp_addr = (exp_addr + 1) % DEPTH;
      if (exp_addr == 0) chk("R6 pointer wrap", {28'd0, rd_addr}, 0);
      else               chk("R5 pointer step", {28'd0, rd_addr}, exp_addr);
      vclk_low();
      fb = DW - 1;
    end
  endtask

  task automatic t_glitches();
    logic [AW-1:0] a0;
    a0 = rd_addr;
    vclk_in = 1'b1; cycles(2); vclk_in = 1'b0; cycles(HOLD);
    chk("R7 vclk glitch no drive", {31'd0, sda_oe}, 0);
    chk("R7 vclk glitch no step", {28'd0, rd_addr}, {28'd0, a0});
    scl_in = 1'b0; cycles(2); scl_in = 1'b1; cycles(HOLD);
    chk("R7 scl glitch no switch", {31'd0, two_wire}, 0);
    chk("R7 scl glitch no pulse", ms_cnt, 0);
    vclk_high();
    chk("R7 next edge gives MSB", {31'd0, sda_out}, {31'd0, pat(exp_addr)[DW-1]});
    vclk_low();
  endtask

  task automatic t_switch();
    logic [AW-1:0] a0;
    vclk_high();
    scl_in = 1'b0;
    cycles(HOLD + 2);
    chk("R8 flag set", {31'd0, two_wire}, 1);
    chk("R8 one pulse", ms_cnt, 1);
    chk("R10 line released", {31'd0, sda_oe}, 0);
    chk("R11 write enable follows high vclk", {31'd0, wr_enable}, 1);
    a0 = rd_addr;
    vclk_low();
    chk("R11 write enable follows low vclk", {31'd0, wr_enable}, 0);
    for (int i = 0; i < 12; i++) begin
      vclk_high();
      chk("R10 no drive in two-wire", {31'd0, sda_oe}, 0);
      vclk_low();
    end
    chk("R10 pointer frozen", {28'd0, rd_addr}, {28'd0, a0});
    scl_in = 1'b1; cycles(HOLD);
    scl_in = 1'b0; cycles(HOLD);
    scl_in = 1'b1; cycles(HOLD);
    chk("R9 flag sticky", {31'd0, two_wire}, 1);
    chk("R9 no second pulse", ms_cnt, 1);
  endtask

  initial begin
    cycles(4);
    rst = 1'b0;
    cycles(HOLD);
    t_reset_state();
    t_warmup();
    t_stream(1, DW - 2);
    t_stream(DEPTH, DW - 1);
    t_glitches();
    t_stream(1, DW - 2);
    t_switch();
    do_reset();
    ms_cnt = 0;
    t_reset_state();
    t_warmup();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule